// File: doc/BRIEF.md
# Compare Output Waveform Unit

This block turns the compare events of one timer channel into a registered output pin level. Two single-cycle strobes come from outside: one pulses when the shared counter matches this channel's own compare value, the other when the counter matches the period value. A 3-bit mode selects what each strobe does to the pin. The pin can be set, cleared or toggled, or a pair of actions can be combined to build edge-aligned or centre-aligned PWM. The counter and the comparators sit outside the block.

The mode and the software level are read in every cycle. A new mode therefore acts on the next strobe that arrives. A new mode on its own never moves the pin, except when the new mode is 000. A timer clear input puts the pin at a fixed low level. The pin always comes from a flop, so it carries no combinational glitch. An asynchronous active-low reset forces the pin low. The release of that reset is synchronised to the clock.

Top module: `cmpout_wave_unit`

## Requirements
- R1: With mode 000, the pin takes the value of `soft_out_i` at the next rising clock edge, and both strobes are ignored.
- R2: With `clr_i` high, the pin is 0 after the next rising clock edge, in every mode and with any strobe. While `rst_n` is low the pin is 0.
- R3: With mode 001, a strobe on `eq_own_i` makes the pin 1 after the next edge. The pin then stays 1 until a clear, a reset or a switch to mode 000.
- R4: With mode 100, each `eq_own_i` strobe inverts the pin at the next edge. Strobes every N cycles therefore give an output period of 2N cycles.
- R5: With mode 101, a strobe on `eq_own_i` makes the pin 0 after the next edge.
- R6: With mode 010, `eq_own_i` inverts the pin. With mode 011, `eq_own_i` sets the pin. In both modes, `eq_per_i` clears the pin.
- R7: With mode 110, `eq_own_i` inverts the pin. With mode 111, `eq_own_i` clears the pin. In both modes, `eq_per_i` sets the pin.
- R8: With modes 010, 011, 110 and 111, when both strobes are high in the same cycle, only the period action (from R6 or R7) is applied. This is also the case on the period channel itself, where both strobes are always the same event.
- R9: With modes 001, 100 and 101, a strobe on `eq_per_i` alone leaves the pin unchanged.
- R10: With any mode other than 000, a cycle with no strobe and no clear leaves the pin unchanged. This holds even when the mode input changes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eq_own_i | input | 1 | Strobe: the counter equals this channel's compare value |
| eq_per_i | input | 1 | Strobe: the counter equals the period value |
| mode_i | input | 3 | Output mode |
| soft_out_i | input | 1 | Software output level, used in mode 000 |
| clr_i | input | 1 | Timer clear; forces the pin low |
| wave_o | output | 1 | Registered output pin level |

## Verification
The properties assume that the strobes, the mode, the software bit and the clear are all synchronous to `clk`. They also assume each input is stable for one full cycle, because the properties sample each input once per edge. They do not depend on how the strobes are spaced, so back-to-back or coincident strobes are allowed. The bench changes every input only on the falling edge. Its random stimulus covers all eight modes, and it draws the strobes independently so that coincident strobes appear often. A rare clear and a change of software level are mixed into the random stream.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_SOFT    = 3'd0,
    MD_SET     = 3'd1,
    MD_TOG_CLR = 3'd2,
    MD_SET_CLR = 3'd3,
    MD_TOG     = 3'd4,
    MD_CLR     = 3'd5,
    MD_TOG_SET = 3'd6,
    MD_CLR_SET = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    ACT_HOLD = 3'd0,
    ACT_SET  = 3'd1,
    ACT_CLR  = 3'd2,
    ACT_TOG  = 3'd3,
    ACT_COPY = 3'd4
  } act_e;

endpackage

// File: rtl/cmpout_rst_sync.sv
module cmpout_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], 1'b1};
  end

  assign rst_q_n = chain_q[LAST];
endmodule

// File: rtl/cmpout_act_decode.sv
module cmpout_act_decode
  import cmpout_pkg::*;
(
  input  mode_e mode,
  output act_e  own_act,
  output act_e  per_act
);
  always_comb begin
    own_act = ACT_HOLD;
    per_act = ACT_HOLD;
    unique case (mode)
      MD_SOFT:    begin own_act = ACT_HOLD; per_act = ACT_HOLD; end
      MD_SET:     begin own_act = ACT_SET;  per_act = ACT_HOLD; end
      MD_TOG_CLR: begin own_act = ACT_TOG;  per_act = ACT_CLR;  end
      MD_SET_CLR: begin own_act = ACT_SET;  per_act = ACT_CLR;  end
      MD_TOG:     begin own_act = ACT_TOG;  per_act = ACT_HOLD; end
      MD_CLR:     begin own_act = ACT_CLR;  per_act = ACT_HOLD; end
      MD_TOG_SET: begin own_act = ACT_TOG;  per_act = ACT_SET;  end
      MD_CLR_SET: begin own_act = ACT_CLR;  per_act = ACT_SET;  end
      default:    begin own_act = ACT_HOLD; per_act = ACT_HOLD; end
    endcase
  end
endmodule

// File: rtl/cmpout_act_merge.sv
module cmpout_act_merge
  import cmpout_pkg::*;
(
  input  mode_e mode,
  input  logic  eq_own,
  input  logic  eq_per,
  input  act_e  own_act,
  input  act_e  per_act,
  output act_e  act
);
  logic per_live;

  assign per_live = eq_per && (per_act != ACT_HOLD);

  always_comb begin
    if (mode == MD_SOFT)   act = ACT_COPY;
    else if (per_live)     act = per_act;
    else if (eq_own)       act = own_act;
    else                   act = ACT_HOLD;
  end
endmodule

// File: rtl/cmpout_out_reg.sv
module cmpout_out_reg
  import cmpout_pkg::*;
#(
  parameter logic CLR_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  act_e act,
  input  logic soft_lvl,
  output logic pin_q
);
  logic pin_d;
  logic pin_en;

  always_comb begin
    pin_en = clr || (act != ACT_HOLD);
    pin_d  = pin_q;
    if (clr) pin_d = CLR_LEVEL;
    else begin
      unique case (act)
        ACT_SET:  pin_d = 1'b1;
        ACT_CLR:  pin_d = 1'b0;
        ACT_TOG:  pin_d = ~pin_q;
        ACT_COPY: pin_d = soft_lvl;
        default:  pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= CLR_LEVEL;
    else if (pin_en) pin_q <= pin_d;
  end
endmodule

// File: rtl/cmpout_wave_unit.sv
module cmpout_wave_unit
  import cmpout_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic CLR_LEVEL   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eq_own_i,
  input  logic       eq_per_i,
  input  logic [2:0] mode_i,
  input  logic       soft_out_i,
  input  logic       clr_i,
  output logic       wave_o
);
  logic  rst_q_n;
  mode_e mode;
  act_e  own_act;
  act_e  per_act;
  act_e  act;

  assign mode = mode_e'(mode_i);

  cmpout_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  cmpout_act_decode u_dec (
    .mode(mode), .own_act(own_act), .per_act(per_act)
  );

  cmpout_act_merge u_mrg (
    .mode(mode), .eq_own(eq_own_i), .eq_per(eq_per_i),
    .own_act(own_act), .per_act(per_act), .act(act)
  );

  cmpout_out_reg #(.CLR_LEVEL(CLR_LEVEL)) u_reg (
    .clk(clk), .rst_n(rst_q_n), .clr(clr_i), .act(act),
    .soft_lvl(soft_out_i), .pin_q(wave_o)
  );
endmodule

// File: rtl/cmpout_wave_chk.sv
module cmpout_wave_chk (
  input logic       clk,
  input logic       rst_ok_n,
  input logic       eq_own_i,
  input logic       eq_per_i,
  input logic [2:0] mode_i,
  input logic       soft_out_i,
  input logic       clr_i,
  input logic       wave_o
);
  // R1
  soft_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_i == 3'd0 && !clr_i) |=> (wave_o == $past(soft_out_i)));
  // R2
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    clr_i |=> !wave_o);
  // R3
  set_own_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_i == 3'd1 && eq_own_i && !clr_i) |=> wave_o);
  // R4
  toggle_own_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_i == 3'd4 && eq_own_i && !clr_i) |=> (wave_o != $past(wave_o)));
  // R5
  reset_own_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_i == 3'd5 && eq_own_i && !clr_i) |=> !wave_o);
  // R6 R8
  per_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((mode_i == 3'd2 || mode_i == 3'd3) && eq_per_i && !clr_i) |=> !wave_o);
  // R7 R8
  per_set_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((mode_i == 3'd6 || mode_i == 3'd7) && eq_per_i && !clr_i) |=> wave_o);
  // R9
  per_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((mode_i == 3'd1 || mode_i == 3'd4 || mode_i == 3'd5) && eq_per_i && !eq_own_i && !clr_i)
      |=> $stable(wave_o));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_i != 3'd0 && !eq_own_i && !eq_per_i && !clr_i) |=> $stable(wave_o));
endmodule

bind cmpout_wave_unit cmpout_wave_chk u_chk (
  .clk(clk), .rst_ok_n(rst_q_n), .eq_own_i(eq_own_i), .eq_per_i(eq_per_i),
  .mode_i(mode_i), .soft_out_i(soft_out_i), .clr_i(clr_i), .wave_o(wave_o)
);

// File: tb/sim_cmpout_wave_unit.sv
`timescale 1ns/1ps
module sim_cmpout_wave_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       eq_own_i, eq_per_i, soft_out_i, clr_i;
  logic [2:0] mode_i;
  logic       wave_o;
  logic       exp_q;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  cmpout_wave_unit u0 (
    .clk(clk), .rst_n(rst_n), .eq_own_i(eq_own_i), .eq_per_i(eq_per_i),
    .mode_i(mode_i), .soft_out_i(soft_out_i), .clr_i(clr_i), .wave_o(wave_o)
  );

  function automatic logic model(logic q, logic [2:0] m, logic eo, logic ep,
                                 logic sw, logic c);
    logic per_hit;
    if (c) return 1'b0;
    if (m == 3'd0) return sw;
    per_hit = ep && (m == 3'd2 || m == 3'd3 || m == 3'd6 || m == 3'd7);
    if (per_hit) return (m == 3'd6 || m == 3'd7);
    if (!eo) return q;
    case (m)
      3'd1, 3'd3: return 1'b1;
      3'd5, 3'd7: return 1'b0;
      default:    return ~q;
    endcase
  endfunction

  task automatic check(string tag, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: wave_o=%b expected %b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(logic [2:0] m, logic eo, logic ep, logic sw, logic c, string tag);
    @(negedge clk);
    mode_i = m; eq_own_i = eo; eq_per_i = ep; soft_out_i = sw; clr_i = c;
    exp_q = model(exp_q, m, eo, ep, sw, c);
    @(posedge clk); #1;
    check(tag, wave_o, exp_q);
  endtask

  initial begin
    rst_n = 1'b0; mode_i = 3'd0; eq_own_i = 0; eq_per_i = 0; soft_out_i = 0; clr_i = 0;
    exp_q = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R2 reset level", wave_o, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R2 after release", wave_o, 1'b0);

    // R1 software level, strobes ignored
    step(3'd0, 1, 1, 1, 0, "R1 copy high");
    step(3'd0, 1, 0, 0, 0, "R1 copy low");
    step(3'd0, 0, 1, 1, 0, "R1 copy high again");
    // R2 clear wins over everything
    step(3'd6, 0, 1, 0, 1, "R2 clear with period set");
    // R3 set and hold
    step(3'd1, 1, 0, 0, 0, "R3 set");
    step(3'd1, 0, 0, 0, 0, "R3 hold");
    step(3'd4, 0, 0, 0, 0, "R10 mode change alone");
    step(3'd5, 0, 0, 0, 0, "R10 mode change alone 2");
    // R9 period strobe ignored
    step(3'd1, 0, 1, 0, 0, "R9 set mode ignores period");
    step(3'd5, 0, 1, 0, 0, "R9 clear mode ignores period");
    // R5
    step(3'd5, 1, 0, 0, 0, "R5 clear");
    // R4 toggle period doubling
    for (int i = 0; i < 6; i++) begin
      step(3'd4, 1, 0, 0, 0, "R4 toggle");
      step(3'd4, 0, 1, 0, 0, "R9 toggle mode ignores period");
    end
    // R6
    step(3'd2, 1, 0, 0, 0, "R6 toggle");
    step(3'd2, 0, 1, 0, 0, "R6 period clear");
    step(3'd3, 1, 0, 0, 0, "R6 set");
    step(3'd3, 0, 1, 0, 0, "R6 period clear 2");
    // R7
    step(3'd7, 0, 1, 0, 0, "R7 period set");
    step(3'd7, 1, 0, 0, 0, "R7 clear");
    step(3'd6, 1, 0, 0, 0, "R7 toggle");
    step(3'd6, 1, 0, 0, 0, "R7 toggle back");
    step(3'd6, 0, 1, 0, 0, "R7 period set 2");
    // R8 coincident strobes
    step(3'd2, 1, 1, 0, 0, "R8 period clear wins");
    step(3'd3, 1, 1, 0, 0, "R8 period clear wins over set");
    step(3'd7, 1, 1, 0, 0, "R8 period set wins");
    step(3'd6, 1, 1, 0, 0, "R8 period set wins over toggle");

    // random mix
    void'($urandom(32'd20240517));
    for (int i = 0; i < 3000; i++) begin
      step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 2) == 0),
           1'($urandom_range(0, 2) == 0), 1'($urandom), 1'($urandom_range(0, 40) == 0),
           "R10 random mix");
    end

    // asynchronous reset mid-run
    step(3'd1, 1, 0, 0, 0, "R3 set before reset");
    #1 rst_n = 1'b0;
    #1 check("R2 async reset", wave_o, 1'b0);
    exp_q = 1'b0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, wave_o=%b expected finish", wave_o);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule